// File: doc/BRIEF.md
# UART In-Band Flow Controller

This block sits beside a UART transmitter and receiver and runs software (in-band) flow control. Every received character is compared against two programmable resume/stop code pairs. A recognised stop code holds the transmitter. A recognised resume code releases it. Recognised codes are removed from the receive stream and the other characters pass through. On the transmit side, a stop or resume request places the matching code ahead of the next queued data byte. A code is only placed when the shifter is idle.

A 4-bit mode word controls both directions. Bits [1:0] select receive recognition and bits [3:2] select transmit insertion. In each field, 10 selects pair 1, 01 selects pair 2 and 11 uses both pairs. In receive mode 11 a code is only recognised when the pair-1 character is followed directly by the pair-2 character. In transmit mode 11 the pair-1 and pair-2 characters are sent back to back.

The block also does the following:
- It can let any received character end a stop hold.
- It reports why the transmitter is held: peer-ready low, data-set-ready low, or a received stop code.
- It remembers whether the last code it sent was a stop or a resume.
- It raises an interrupt with identification code 0x10 when it recognises a flow code.

Baud generation, serialisation and FIFOs belong to neighbouring blocks.

Top module: `xonxoff_flow`

## Requirements
- R1: After reset the block is in this state, with ctsIn and dsrIn high:
  - txHold is 0 and flowStatus is 0.
  - xonFlag is 1 and xonSent is 0.
  - irq is 0 and irqId is 0x01.
  - rxOutValid is 0.
- R2: With modeSel[1:0]=10, a received xoff1Code sets the stop hold (flowStatus[2]) and a received xon1Code clears it. Neither code is forwarded. Pair-2 codes are forwarded as data and leave the hold unchanged.
- R3: With modeSel[1:0]=01, xoff2Code sets the hold and xon2Code clears it. Both codes are consumed, and pair-1 codes are forwarded as data.
- R4: With modeSel[1:0]=00, every received character is forwarded and the stop hold does not change.
- R5: With modeSel[1:0]=11, a stop is recognised only when xoff1Code is directly followed by xoff2Code, and a resume only when xon1Code is directly followed by xon2Code. Any other character in between cancels the partial match. The leading character is forwarded, and only the completing character is consumed.
- R6: With xonAny set and receive recognition on, any received character that is not a stop code clears the stop hold. A character that is not itself a resume code is still forwarded.
- R7: A forwarded character appears on rxOutData with rxOutValid high in the cycle after it was presented on rxData with rxValid.
- R8: The status bits are defined as follows:
  - flowStatus[0] is !ctsIn and flowStatus[1] is !dsrIn, both without delay.
  - flowStatus[2] is the stop hold.
  - txHold is the OR of flowStatus[2:0].
  - xonFlag is the inverse of flowStatus[2].
- R9: With intEn set, a recognised flow code sets irq from the next cycle, with irqId 0x10. irqAck clears it back to irqId 0x01. With intEn clear, no interrupt is raised.
- R10: A sendXoff or sendXon pulse is taken at the clock edge. The code is then loaded on txLoad/txChar in the first following cycle with shifterBusy low. The code goes ahead of pending data and is sent even while txHold is high. Transmit mode 10 sends pair-1 codes and mode 01 sends pair-2 codes.
- R11: With modeSel[3:2]=11, a request loads the pair-1 code and then the pair-2 code in consecutive idle cycles.
- R12: With modeSel[3:2]=00, stop and resume requests are discarded, even if the mode changes afterwards.
- R13: A data byte is loaded (txLoad high, txChar=txData, txDataTake high) only in a cycle with shifterBusy low, txHold low, txDataValid high and no flow code pending.
- R14: After the last character of a stop code has been loaded, flowStatus[3] is 1 and xonSent is 0. After the last character of a resume code has been loaded, xonSent is 1 and flowStatus[3] is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| xon1Code | input | 8 | Resume code, pair 1 |
| xon2Code | input | 8 | Resume code, pair 2 |
| xoff1Code | input | 8 | Stop code, pair 1 |
| xoff2Code | input | 8 | Stop code, pair 2 |
| modeSel | input | 4 | [3:2] transmit mode, [1:0] receive mode |
| xonAny | input | 1 | Any received character ends a stop hold |
| intEn | input | 1 | Interrupt enable for recognised codes |
| irqAck | input | 1 | Clears a pending interrupt |
| rxValid | input | 1 | Received character strobe |
| rxData | input | 8 | Received character |
| rxOutValid | output | 1 | Forwarded character strobe |
| rxOutData | output | 8 | Forwarded character |
| ctsIn | input | 1 | Peer ready to receive (low holds the transmitter) |
| dsrIn | input | 1 | Data set ready (low holds the transmitter) |
| sendXon | input | 1 | Request to send a resume code |
| sendXoff | input | 1 | Request to send a stop code |
| shifterBusy | input | 1 | Transmit shifter is sending a byte |
| txDataValid | input | 1 | A data byte is waiting |
| txData | input | 8 | Waiting data byte |
| txDataTake | output | 1 | The waiting data byte is loaded this cycle |
| txLoad | output | 1 | Load txChar into the shifter |
| txChar | output | 8 | Character to load |
| txHold | output | 1 | Transmitter held for data |
| flowStatus | output | 4 | {stop sent, stop hold, dsr hold, cts hold} |
| xonFlag | output | 1 | Resume state (no stop hold) |
| xonSent | output | 1 | Last code sent was a resume |
| irq | output | 1 | Interrupt pending |
| irqId | output | 6 | 0x10 when pending, 0x01 otherwise |

## Verification
Results arrive at different times:
- Receive-side results (the forwarded character, the stop hold, xonFlag and the interrupt) settle one clock edge after the character strobe.
- The peer-ready and data-set-ready hold bits follow their inputs within the same cycle.
- An injected code is first offered in the cycle after the request edge. Its sent flag appears one edge after its last character is loaded.

The bench drives stimulus at the falling edge. It reads registered results at the next falling edge and reads the combinational load outputs a nanosecond after it changes their inputs. The second character of a paired code is checked at the following falling edge.

// File: rtl/xonxoff_pkg.sv
package xonxoff_pkg;
  localparam int CHAR_W = 8;
  localparam int ID_W   = 6;

  typedef enum logic [1:0] {
    SEQ_IDLE      = 2'd0,
    SEQ_ON_LEAD   = 2'd1,
    SEQ_OFF_LEAD  = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic rxPass;
    logic injLoad;
    logic injOff;
    logic injPair2;
    logic dataLoad;
  } dpStrobe_t;
endpackage

// File: rtl/xonxoff_ctrl.sv
module xonxoff_ctrl
  import xonxoff_pkg::*;
#(
  parameter int CW = CHAR_W,
  parameter int IDW = ID_W,
  parameter logic [IDW-1:0] ID_FLOW = 6'h10,
  parameter logic [IDW-1:0] ID_NONE = 6'h01
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [CW-1:0]  xon1Code,
  input  logic [CW-1:0]  xon2Code,
  input  logic [CW-1:0]  xoff1Code,
  input  logic [CW-1:0]  xoff2Code,
  input  logic [3:0]     modeSel,
  input  logic           xonAny,
  input  logic           intEn,
  input  logic           irqAck,
  input  logic           rxValid,
  input  logic [CW-1:0]  rxData,
  input  logic           ctsIn,
  input  logic           dsrIn,
  input  logic           sendXon,
  input  logic           sendXoff,
  input  logic           shifterBusy,
  input  logic           txDataValid,
  output dpStrobe_t      strobe,
  output logic           txHold,
  output logic [3:0]     flowStatus,
  output logic           xonFlag,
  output logic           xonSent,
  output logic           irq,
  output logic [IDW-1:0] irqId
);
  localparam int NP = 2;

  logic [CW-1:0] onCode  [NP];
  logic [CW-1:0] offCode [NP];
  logic [NP-1:0] onHit, offHit, pairEn;

  assign onCode[0]  = xon1Code;
  assign onCode[1]  = xon2Code;
  assign offCode[0] = xoff1Code;
  assign offCode[1] = xoff2Code;

  genvar p;
  for (p = 0; p < NP; p++) begin : g_pair
    assign onHit[p]  = (rxData == onCode[p]);
    assign offHit[p] = (rxData == offCode[p]);
  end

  // ---------------- receive recognition ----------------
  logic [1:0] rxMode, txMode;
  logic       seqMode, singleOn, singleOff, seqOn, seqOff;
  logic       isOn, isOff, flowEvt, releaseEvt;
  seqState_t  seqSt;
  logic       holdXoff, irqPend;

  assign rxMode  = modeSel[1:0];
  assign txMode  = modeSel[3:2];
  assign pairEn  = {rxMode[0], rxMode[1]};
  assign seqMode = &rxMode;

  assign singleOff = ~seqMode & |(offHit & pairEn);
  assign singleOn  = ~seqMode & |(onHit & pairEn);
  assign seqOff    = seqMode & (seqSt == SEQ_OFF_LEAD) & offHit[1];
  assign seqOn     = seqMode & (seqSt == SEQ_ON_LEAD) & onHit[1];
  assign isOff     = singleOff | seqOff;
  assign isOn      = (singleOn | seqOn) & ~isOff;
  assign flowEvt   = rxValid & (isOff | isOn);
  assign releaseEvt = rxValid & ~isOff & (isOn | (xonAny & |rxMode));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqSt    <= SEQ_IDLE;
      holdXoff <= 1'b0;
      irqPend  <= 1'b0;
    end else begin
      if (!seqMode)
        seqSt <= SEQ_IDLE;
      else if (rxValid) begin
        if (seqOff | seqOn)  seqSt <= SEQ_IDLE;
        else if (offHit[0])  seqSt <= SEQ_OFF_LEAD;
        else if (onHit[0])   seqSt <= SEQ_ON_LEAD;
        else                 seqSt <= SEQ_IDLE;
      end

      if (rxValid & isOff)  holdXoff <= 1'b1;
      else if (releaseEvt)  holdXoff <= 1'b0;

      if (flowEvt & intEn)  irqPend <= 1'b1;
      else if (irqAck)      irqPend <= 1'b0;
    end
  end

  // ---------------- transmit injection ----------------
  logic txEn, reqValid, reqOff, reqStep, injLoad, lastInj;
  logic xoffSentQ, xonSentQ;

  assign txEn    = |txMode;
  assign injLoad = reqValid & txEn & ~shifterBusy;
  assign lastInj = injLoad & ~((txMode == 2'b11) & ~reqStep);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqValid  <= 1'b0;
      reqOff    <= 1'b0;
      reqStep   <= 1'b0;
      xoffSentQ <= 1'b0;
      xonSentQ  <= 1'b0;
    end else begin
      if (!txEn)
        reqValid <= 1'b0;
      else if (sendXoff | sendXon) begin
        reqValid <= 1'b1;
        reqOff   <= sendXoff;
        reqStep  <= 1'b0;
      end else if (injLoad) begin
        if (lastInj) reqValid <= 1'b0;
        else         reqStep  <= 1'b1;
      end

      if (lastInj) begin
        xoffSentQ <= reqOff;
        xonSentQ  <= ~reqOff;
      end
    end
  end

  // ---------------- outputs ----------------
  assign txHold     = holdXoff | ~ctsIn | ~dsrIn;
  assign flowStatus = {xoffSentQ, holdXoff, ~dsrIn, ~ctsIn};
  assign xonFlag    = ~holdXoff;
  assign xonSent    = xonSentQ;
  assign irq        = irqPend;
  assign irqId      = irqPend ? ID_FLOW : ID_NONE;

  always_comb begin
    strobe.rxPass   = rxValid & ~(isOff | isOn);
    strobe.injLoad  = injLoad;
    strobe.injOff   = reqOff;
    strobe.injPair2 = (txMode == 2'b01) | ((txMode == 2'b11) & reqStep);
    strobe.dataLoad = ~(reqValid & txEn) & ~shifterBusy & ~txHold & txDataValid;
  end

  // ---------------- assertions ----------------
  a_r13_idle_shifter: assert property (@(posedge clk) disable iff (!rstN)
    shifterBusy |-> (!strobe.injLoad && !strobe.dataLoad));
  a_r8_hold_blocks_data: assert property (@(posedge clk) disable iff (!rstN)
    txHold |-> !strobe.dataLoad);
  a_r12_no_inject_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (txMode == 2'b00) |-> !strobe.injLoad);
  a_r14_sent_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(xoffSentQ && xonSentQ));
  a_r4_off_mode_keeps_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rxMode == 2'b00) |=> $stable(holdXoff));
  a_r2_hold_needs_char: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |=> $stable(holdXoff));
  a_r9_no_spurious_irq: assert property (@(posedge clk) disable iff (!rstN)
    (!rxValid && !irqPend) |=> !irqPend);
endmodule

// File: rtl/xonxoff_dp.sv
module xonxoff_dp
  import xonxoff_pkg::*;
#(
  parameter int CW = CHAR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strobe,
  input  logic [CW-1:0] rxData,
  input  logic [CW-1:0] xon1Code,
  input  logic [CW-1:0] xon2Code,
  input  logic [CW-1:0] xoff1Code,
  input  logic [CW-1:0] xoff2Code,
  input  logic [CW-1:0] txData,
  output logic          rxOutValid,
  output logic [CW-1:0] rxOutData,
  output logic          txLoad,
  output logic [CW-1:0] txChar,
  output logic          txDataTake
);
  logic [CW-1:0] injChar;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxOutValid <= 1'b0;
      rxOutData  <= '0;
    end else begin
      rxOutValid <= strobe.rxPass;
      if (strobe.rxPass) rxOutData <= rxData;
    end
  end

  always_comb begin
    unique case ({strobe.injOff, strobe.injPair2})
      2'b00:   injChar = xon1Code;
      2'b01:   injChar = xon2Code;
      2'b10:   injChar = xoff1Code;
      default: injChar = xoff2Code;
    endcase
  end

  assign txLoad     = strobe.injLoad | strobe.dataLoad;
  assign txChar     = strobe.injLoad ? injChar : txData;
  assign txDataTake = strobe.dataLoad;

  a_r10_one_source: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.injLoad && strobe.dataLoad));
  a_r10_inj_is_code: assert property (@(posedge clk) disable iff (!rstN)
    (txLoad && !txDataTake) |->
      (txChar == xon1Code || txChar == xon2Code ||
       txChar == xoff1Code || txChar == xoff2Code));
endmodule

// File: rtl/xonxoff_flow.sv
module xonxoff_flow
  import xonxoff_pkg::*;
#(
  parameter int CW = CHAR_W,
  parameter int IDW = ID_W,
  parameter logic [IDW-1:0] ID_FLOW = 6'h10,
  parameter logic [IDW-1:0] ID_NONE = 6'h01
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [CW-1:0]  xon1Code,
  input  logic [CW-1:0]  xon2Code,
  input  logic [CW-1:0]  xoff1Code,
  input  logic [CW-1:0]  xoff2Code,
  input  logic [3:0]     modeSel,
  input  logic           xonAny,
  input  logic           intEn,
  input  logic           irqAck,
  input  logic           rxValid,
  input  logic [CW-1:0]  rxData,
  output logic           rxOutValid,
  output logic [CW-1:0]  rxOutData,
  input  logic           ctsIn,
  input  logic           dsrIn,
  input  logic           sendXon,
  input  logic           sendXoff,
  input  logic           shifterBusy,
  input  logic           txDataValid,
  input  logic [CW-1:0]  txData,
  output logic           txDataTake,
  output logic           txLoad,
  output logic [CW-1:0]  txChar,
  output logic           txHold,
  output logic [3:0]     flowStatus,
  output logic           xonFlag,
  output logic           xonSent,
  output logic           irq,
  output logic [IDW-1:0] irqId
);
  dpStrobe_t strobe;

  xonxoff_ctrl #(.CW(CW), .IDW(IDW), .ID_FLOW(ID_FLOW), .ID_NONE(ID_NONE)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .xon1Code(xon1Code), .xon2Code(xon2Code),
    .xoff1Code(xoff1Code), .xoff2Code(xoff2Code),
    .modeSel(modeSel), .xonAny(xonAny), .intEn(intEn), .irqAck(irqAck),
    .rxValid(rxValid), .rxData(rxData), .ctsIn(ctsIn), .dsrIn(dsrIn),
    .sendXon(sendXon), .sendXoff(sendXoff), .shifterBusy(shifterBusy),
    .txDataValid(txDataValid), .strobe(strobe), .txHold(txHold),
    .flowStatus(flowStatus), .xonFlag(xonFlag), .xonSent(xonSent),
    .irq(irq), .irqId(irqId)
  );

  xonxoff_dp #(.CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxData(rxData),
    .xon1Code(xon1Code), .xon2Code(xon2Code),
    .xoff1Code(xoff1Code), .xoff2Code(xoff2Code),
    .txData(txData), .rxOutValid(rxOutValid), .rxOutData(rxOutData),
    .txLoad(txLoad), .txChar(txChar), .txDataTake(txDataTake)
  );

  a_r7_out_needs_input: assert property (@(posedge clk) disable iff (!rstN)
    rxOutValid |-> $past(rxValid));
  a_r9_id_tracks_irq: assert property (@(posedge clk) disable iff (!rstN)
    irqId == (irq ? ID_FLOW : ID_NONE));
endmodule

// File: tb/xonxoff_flow_test.sv
`timescale 1ns/1ps
module xonxoff_flow_test;
  logic clk = 1'b0;
  logic rstN;
  logic [7:0] xon1Code, xon2Code, xoff1Code, xoff2Code;
  logic [3:0] modeSel;
  logic xonAny, intEn, irqAck, rxValid;
  logic [7:0] rxData;
  logic rxOutValid;
  logic [7:0] rxOutData;
  logic ctsIn, dsrIn, sendXon, sendXoff, shifterBusy, txDataValid;
  logic [7:0] txData;
  logic txDataTake, txLoad;
  logic [7:0] txChar;
  logic txHold;
  logic [3:0] flowStatus;
  logic xonFlag, xonSent, irq;
  logic [5:0] irqId;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  xonxoff_flow uut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sendRx(logic [3:0] m, logic [7:0] c);
    @(negedge clk);
    modeSel = m; rxValid = 1'b1; rxData = c;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  // {modeSel, character, expect forwarded, expect stop hold}
  localparam logic [13:0] VEC [15] = '{
    {4'b0010, 8'h41, 1'b1, 1'b0},
    {4'b0010, 8'h13, 1'b0, 1'b1},
    {4'b0010, 8'h93, 1'b1, 1'b1},
    {4'b0010, 8'h11, 1'b0, 1'b0},
    {4'b0001, 8'h13, 1'b1, 1'b0},
    {4'b0001, 8'h93, 1'b0, 1'b1},
    {4'b0001, 8'h91, 1'b0, 1'b0},
    {4'b0000, 8'h13, 1'b1, 1'b0},
    {4'b0011, 8'h13, 1'b1, 1'b0},
    {4'b0011, 8'h41, 1'b1, 1'b0},
    {4'b0011, 8'h93, 1'b1, 1'b0},
    {4'b0011, 8'h13, 1'b1, 1'b0},
    {4'b0011, 8'h93, 1'b0, 1'b1},
    {4'b0011, 8'h11, 1'b1, 1'b1},
    {4'b0011, 8'h91, 1'b0, 1'b0}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    xon1Code = 8'h11; xoff1Code = 8'h13; xon2Code = 8'h91; xoff2Code = 8'h93;
    modeSel = 4'b0000; xonAny = 1'b0; intEn = 1'b0; irqAck = 1'b0;
    rxValid = 1'b0; rxData = 8'h00; ctsIn = 1'b1; dsrIn = 1'b1;
    sendXon = 1'b0; sendXoff = 1'b0; shifterBusy = 1'b1;
    txDataValid = 1'b1; txData = 8'hA5;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 txHold", txHold, 0);
    chk("R1 flowStatus", flowStatus, 0);
    chk("R1 xonFlag", xonFlag, 1);
    chk("R1 xonSent", xonSent, 0);
    chk("R1 irq", irq, 0);
    chk("R1 irqId", irqId, 6'h01);
    chk("R1 rxOutValid", rxOutValid, 0);

    // table of receive patterns: R2 R3 R4 R5, forwarding R7
    for (int i = 0; i < 15; i++) begin
      string tag;
      case (VEC[i][13:10])
        4'b0010: tag = "R2";
        4'b0001: tag = "R3";
        4'b0000: tag = "R4";
        default: tag = "R5";
      endcase
      sendRx(VEC[i][13:10], VEC[i][9:2]);
      chk($sformatf("%s row%0d forwarded", tag, i), rxOutValid, VEC[i][1]);
      chk($sformatf("%s row%0d hold", tag, i), flowStatus[2], VEC[i][0]);
      if (VEC[i][1]) chk($sformatf("R7 row%0d data", i), rxOutData, VEC[i][9:2]);
    end

    // R6 any character resumes
    xonAny = 1'b1;
    sendRx(4'b0010, 8'h13);
    chk("R6 held by stop", flowStatus[2], 1);
    sendRx(4'b0010, 8'h41);
    chk("R6 released", flowStatus[2], 0);
    chk("R6 char forwarded", rxOutValid, 1);
    chk("R6 char value", rxOutData, 8'h41);
    xonAny = 1'b0;

    // R9 interrupt, R8 xonFlag
    intEn = 1'b1;
    sendRx(4'b0010, 8'h13);
    chk("R9 irq set", irq, 1);
    chk("R9 irqId flow", irqId, 6'h10);
    chk("R8 xonFlag low", xonFlag, 0);
    chk("R8 txHold by stop", txHold, 1);
    irqAck = 1'b1;
    @(negedge clk);
    irqAck = 1'b0;
    chk("R9 irq acked", irq, 0);
    chk("R9 irqId idle", irqId, 6'h01);
    intEn = 1'b0;
    sendRx(4'b0010, 8'h11);
    chk("R9 no irq when disabled", irq, 0);
    chk("R2 resume clears hold", flowStatus[2], 0);

    // R8 peer-ready and data-set-ready holds
    @(negedge clk);
    ctsIn = 1'b0; #1;
    chk("R8 cts bit", flowStatus[1:0], 2'b01);
    chk("R8 cts hold", txHold, 1);
    ctsIn = 1'b1; dsrIn = 1'b0; #1;
    chk("R8 dsr bit", flowStatus[1:0], 2'b10);
    chk("R8 dsr hold", txHold, 1);
    dsrIn = 1'b1; #1;
    chk("R8 hold clear", txHold, 0);

    // R10 stop code, pair 1, ahead of data, waits for idle shifter
    @(negedge clk);
    modeSel = 4'b1000; shifterBusy = 1'b1; sendXoff = 1'b1;
    @(negedge clk);
    sendXoff = 1'b0; #1;
    chk("R10 waits for busy shifter", txLoad, 0);
    shifterBusy = 1'b0; #1;
    chk("R10 stop loaded", txLoad, 1);
    chk("R10 stop char", txChar, 8'h13);
    chk("R10 data waits", txDataTake, 0);
    @(negedge clk);
    chk("R13 data after code", txDataTake, 1);
    chk("R13 data char", txChar, 8'hA5);
    chk("R14 stop sent", flowStatus[3], 1);
    chk("R14 resume flag clear", xonSent, 0);

    // R11 paired resume
    shifterBusy = 1'b1; modeSel = 4'b1100; sendXon = 1'b1;
    @(negedge clk);
    sendXon = 1'b0; shifterBusy = 1'b0; #1;
    chk("R11 first char", txChar, 8'h11);
    chk("R11 first not data", txDataTake, 0);
    @(negedge clk);
    chk("R11 second char", txChar, 8'h91);
    chk("R11 second not data", txDataTake, 0);
    @(negedge clk);
    chk("R11 then data", txDataTake, 1);
    chk("R14 resume sent", xonSent, 1);
    chk("R14 stop flag clear", flowStatus[3], 0);

    // R10 pair 2 resume
    shifterBusy = 1'b1; modeSel = 4'b0100; sendXon = 1'b1;
    @(negedge clk);
    sendXon = 1'b0; shifterBusy = 1'b0; #1;
    chk("R10 pair2 resume char", txChar, 8'h91);
    @(negedge clk);

    // R10 code sent during hold, R13 data held
    shifterBusy = 1'b1; modeSel = 4'b1000; ctsIn = 1'b0; sendXoff = 1'b1;
    @(negedge clk);
    sendXoff = 1'b0; shifterBusy = 1'b0; #1;
    chk("R10 code under hold", txLoad, 1);
    chk("R10 code under hold char", txChar, 8'h13);
    @(negedge clk);
    chk("R13 no load while held", txLoad, 0);
    chk("R13 no take while held", txDataTake, 0);
    ctsIn = 1'b1; #1;
    chk("R13 load after release", txDataTake, 1);

    // R12 request discarded with transmit mode off
    @(negedge clk);
    shifterBusy = 1'b1; modeSel = 4'b0000; sendXoff = 1'b1;
    @(negedge clk);
    sendXoff = 1'b0; modeSel = 4'b1000; shifterBusy = 1'b0; #1;
    chk("R12 data not code", txChar, 8'hA5);
    chk("R12 data taken", txDataTake, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule